// File: doc/BRIEF.md
# Partitioned Tree Pseudo-LRU Victim Selector

This block tracks recency for one 16-way cache set using a binary tree of pseudo-LRU bits. Each access moves the bits on the accessed way's path so that they point away from that way. On request, the block walks the tree from the root to a leaf and names a victim way.

Some ways in the set may hold only tags, with no data storage. These tag-only ways always occupy the lowest indices, and their number is given at runtime. Of these, a few are fixed in the layout and the rest are switched off dynamically. When the requester needs a way that has data storage, it asserts the restrict input. The walk then stays inside the upper index range that holds the data-capable ways. This mode is used when filling a line that carries data, and when moving a written-back line out of a tag-only way. The boundary need not fall on a subtree edge. At any node whose preferred child covers only forbidden ways, the walk takes the other child instead.

Top module: `plru_part_top`

## Requirements
- R1: Synchronous active-high reset clears every tree bit and drops `vic_valid`. An unrestricted request after reset, with no access in between, yields way 0.
- R2: An access to way w sets every node on w's path to point at the sibling subtree: bit 1 where w lies in the lower half of that node, bit 0 where it lies in the upper half. An unrestricted victim taken right after an access therefore never names the way just accessed.
- R3: An unrestricted walk starts at the root and follows each node bit down to a leaf. A bit of 0 selects the lower-index child and a bit of 1 selects the higher-index child.
- R4: With `vic_restrict` high, every valid victim has an index at least `dl_count`, the number of tag-only ways, which sit at indices 0 to `dl_count`-1.
- R5: In a restricted walk, a node whose bit selects a child that covers no allowed way is steered to the other child. A node whose selected child holds at least one allowed way keeps its bit.
- R6: With `vic_restrict` high and `dl_count` at or above 16, no way is allowed and `vic_valid` stays low. Values above 16 are treated as 16.
- R7: The victim and its valid flag are registered. They appear in the cycle after `vic_req`. `vic_valid` is low in any cycle that does not follow a request.
- R8: When an access and a request arrive in the same cycle, the victim is taken from the tree as it was before that access.
- R9: With `vic_restrict` low, `dl_count` has no effect on the victim.
- R10: A victim request alone does not change the tree bits. Back-to-back requests with no access between them name the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access to `acc_way` happens this cycle |
| acc_way | input | 4 | Way being accessed |
| vic_req | input | 1 | Request a victim this cycle |
| vic_restrict | input | 1 | Confine the victim to the data-capable ways |
| dl_count | input | 5 | Number of tag-only ways at the low end of the set (0 to 16) |
| vic_valid | output | 1 | Registered: a victim was found for last cycle's request |
| vic_way | output | 4 | Registered victim way |

## Verification
The bench targets boundaries that do not sit on a subtree edge, such as 3, 5 and 15. At these a walk that never overrides a node would return a tag-only way, and one that overrides too eagerly would leave the correct LRU path. It drives counts of exactly 16 and above 16 with the restrict flag both set and clear. A wrong clamp there would either report a victim when none exists or suppress one that should be valid. It also issues an access together with a request in the same cycle, and back-to-back requests with no access between them. A design that read the updated tree, or that changed state on a request, would return a different way in those cases.

// File: rtl/plru_pkg.sv
package plru_pkg;

    localparam int unsigned PLRU_WAYS  = 16;
    localparam int unsigned PLRU_LVLS  = $clog2(PLRU_WAYS);
    localparam int unsigned PLRU_NODES = PLRU_WAYS - 1;

    typedef logic [PLRU_LVLS-1:0] way_t;
    typedef logic [PLRU_LVLS:0]   cnt_t;
    typedef logic [PLRU_LVLS-1:0] node_t;
    typedef logic [PLRU_NODES-1:0] tree_t;

    typedef struct packed {
        logic valid;
        way_t way;
    } pick_t;

    localparam cnt_t PLRU_WAYS_C = cnt_t'(PLRU_WAYS);

    // Zero-based storage slot of the tree node that way w passes at level lvl.
    function automatic node_t node_slot(way_t w, int unsigned lvl);
        int unsigned heap;
        heap = (32'd1 << lvl) | (32'(w) >> (PLRU_LVLS - lvl));
        return node_t'(heap - 32'd1);
    endfunction

    // Bit value that makes a node point away from way w at level lvl.
    function automatic logic away_bit(way_t w, int unsigned lvl);
        return ~w[PLRU_LVLS-1-lvl];
    endfunction

endpackage

// File: rtl/plru_bound.sv
module plru_bound
    import plru_pkg::*;
(
    input  logic restrict_en,
    input  cnt_t dl_count,
    output cnt_t lo_way,
    output logic any_ok
);

    cnt_t clamped;

    always_comb begin
        clamped = (dl_count > PLRU_WAYS_C) ? PLRU_WAYS_C : dl_count;
        lo_way  = restrict_en ? clamped : '0;
        any_ok  = (lo_way < PLRU_WAYS_C);
    end

endmodule

// File: rtl/plru_state.sv
module plru_state
    import plru_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  acc_valid,
    input  way_t  acc_way,
    output tree_t tree
);

    tree_t tree_q;
    tree_t tree_d;

    always_comb begin
        tree_d = tree_q;
        if (acc_valid) begin
            for (int unsigned lvl = 0; lvl < PLRU_LVLS; lvl++) begin
                tree_d[node_slot(acc_way, lvl)] = away_bit(acc_way, lvl);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) tree_q <= '0;
        else     tree_q <= tree_d;
    end

    assign tree = tree_q;

    // R10: without an access the tree holds its value
    p_tree_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> $stable(tree_q));

endmodule

// File: rtl/plru_walk.sv
module plru_walk
    import plru_pkg::*;
(
    input  tree_t tree,
    input  cnt_t  lo_way,
    output way_t  vic_way
);

    node_t hidx [PLRU_LVLS];
    way_t  base [PLRU_LVLS+1];

    assign hidx[0] = node_t'(1);
    assign base[0] = '0;

    for (genvar l = 0; l < PLRU_LVLS; l++) begin : g_lvl
        localparam int unsigned HALF   = PLRU_WAYS >> (l + 1);
        localparam cnt_t        HALF_C = cnt_t'(HALF);
        localparam way_t        HALF_W = way_t'(HALF);

        logic pref;
        logic left_ok;
        logic go_right;

        assign pref     = tree[node_t'(hidx[l] - node_t'(1))];
        assign left_ok  = lo_way < ({1'b0, base[l]} + HALF_C);
        assign go_right = pref | ~left_ok;
        assign base[l+1] = base[l] + (go_right ? HALF_W : '0);

        if (l + 1 < PLRU_LVLS) begin : g_next
            assign hidx[l+1] = {hidx[l][PLRU_LVLS-2:0], go_right};
        end
    end

    assign vic_way = base[PLRU_LVLS];

endmodule

// File: rtl/plru_part_top.sv
module plru_part_top
    import plru_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_valid,
    input  logic [PLRU_LVLS-1:0] acc_way,
    input  logic                 vic_req,
    input  logic                 vic_restrict,
    input  logic [PLRU_LVLS:0]   dl_count,
    output logic                 vic_valid,
    output logic [PLRU_LVLS-1:0] vic_way
);

    tree_t tree;
    cnt_t  lo_way;
    logic  any_ok;
    way_t  walk_way;
    pick_t pick_q;

    plru_bound u_bound (
        .restrict_en (vic_restrict),
        .dl_count    (dl_count),
        .lo_way      (lo_way),
        .any_ok      (any_ok)
    );

    plru_state u_state (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_way   (acc_way),
        .tree      (tree)
    );

    plru_walk u_walk (
        .tree    (tree),
        .lo_way  (lo_way),
        .vic_way (walk_way)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pick_q <= '0;
        end else begin
            pick_q.valid <= vic_req & any_ok;
            if (vic_req & any_ok) pick_q.way <= walk_way;
        end
    end

    assign vic_valid = pick_q.valid;
    assign vic_way   = pick_q.way;

    // R7: a valid victim only follows a request
    p_valid_needs_req_r7: assert property (@(posedge clk) disable iff (rst)
        !vic_req |=> !vic_valid);

    // R4: restricted victims stay above the tag-only range
    p_victim_allowed_r4: assert property (@(posedge clk) disable iff (rst)
        (vic_req && vic_restrict) |=> (!vic_valid || ({1'b0, vic_way} >= $past(dl_count))));

    // R6: no allowed way means no valid victim
    p_none_allowed_r6: assert property (@(posedge clk) disable iff (rst)
        (vic_req && vic_restrict && (dl_count >= PLRU_WAYS_C)) |=> !vic_valid);

    // R2: an unrestricted victim right after an access avoids that way
    p_avoid_recent_r2: assert property (@(posedge clk) disable iff (rst)
        (vic_req && !vic_restrict && $past(acc_valid) && !$past(rst))
        |=> (vic_way != $past(acc_way, 2)));

endmodule

// File: tb/plru_part_top_bench.sv
`timescale 1ns/1ps
module plru_part_top_bench;
    import plru_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_valid = 1'b0;
    logic [3:0] acc_way = '0;
    logic       vic_req = 1'b0;
    logic       vic_restrict = 1'b0;
    logic [4:0] dl_count = '0;
    logic       vic_valid;
    logic [3:0] vic_way;

    int checks = 0;
    int errors = 0;
    logic [14:0] mt = '0;

    always #2 clk = ~clk;

    plru_part_top u_plru_part_top (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_way(acc_way),
        .vic_req(vic_req), .vic_restrict(vic_restrict), .dl_count(dl_count),
        .vic_valid(vic_valid), .vic_way(vic_way)
    );

    task automatic check(input logic ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Reference victim from the requirement text (R3, R5, R6).
    task automatic model_pick(input logic rs, input logic [4:0] c,
                              output logic ev, output logic [3:0] ew);
        int lo, idx, b, half;
        logic gr;
        lo = rs ? ((c > 16) ? 16 : int'(c)) : 0;
        ev = (lo < 16);
        idx = 1; b = 0;
        for (int l = 0; l < 4; l++) begin
            half = 16 >> (l + 1);
            gr = mt[idx-1] || (lo >= b + half);
            if (gr) b = b + half;
            idx = idx * 2 + (gr ? 1 : 0);
        end
        ew = 4'(b);
    endtask

    // Reference update (R2).
    task automatic model_touch(input logic [3:0] w);
        int idx;
        idx = 1;
        for (int l = 0; l < 4; l++) begin
            mt[idx-1] = ~w[3-l];
            idx = idx * 2 + int'(w[3-l]);
        end
    endtask

    task automatic step(input logic a, input logic [3:0] aw, input logic r,
                        input logic rs, input logic [4:0] c, input string tag);
        logic ev;
        logic [3:0] ew;
        acc_valid = a; acc_way = aw; vic_req = r; vic_restrict = rs; dl_count = c;
        model_pick(rs, c, ev, ew);
        if (a) model_touch(aw);
        @(posedge clk);
        @(negedge clk);
        if (r) begin
            check(vic_valid == ev, tag, int'(vic_valid), int'(ev));
            if (ev) check(vic_way == ew, tag, int'(vic_way), int'(ew));
        end else begin
            check(vic_valid == 1'b0, "R7 idle", int'(vic_valid), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] prev;
        string tag;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(vic_valid == 1'b0, "R1 reset valid", int'(vic_valid), 0);
        step(0, 0, 1, 0, 0, "R1 first victim");
        check(vic_way == 4'd0, "R1 way0", int'(vic_way), 0);
        step(1, 0, 0, 0, 0, "R7");
        step(0, 0, 1, 0, 0, "R2 after access 0");
        check(vic_way == 4'd8, "R2 away", int'(vic_way), 8);
        prev = vic_way;
        step(0, 0, 1, 0, 0, "R10 repeat");
        check(vic_way == prev, "R10 stable", int'(vic_way), int'(prev));
        step(1, 8, 1, 0, 0, "R8 same cycle");
        check(vic_way == 4'd8, "R8 old tree", int'(vic_way), 8);
        step(0, 0, 1, 0, 0, "R2 after access 8");
        check(vic_way == 4'd4, "R2 walk", int'(vic_way), 4);
        step(0, 0, 1, 0, 16, "R9 count ignored");
        check(vic_way == 4'd4, "R9 way", int'(vic_way), 4);
        step(0, 0, 1, 1, 16, "R6 full");
        step(0, 0, 1, 1, 20, "R6 above");
        step(0, 0, 1, 1, 5, "R5 boundary 5");
        check(vic_way >= 4'd5, "R4 boundary 5", int'(vic_way), 5);
        step(0, 0, 1, 1, 3, "R5 boundary 3");
        step(0, 0, 1, 1, 15, "R5 only way 15");
        check(vic_way == 4'd15, "R4 way15", int'(vic_way), 15);
        step(0, 0, 1, 1, 8, "R4 aligned 8");
        step(0, 0, 1, 1, 0, "R3 restrict zero");
        for (int i = 0; i < 4000; i++) begin
            logic a, r, rs;
            logic [3:0] aw;
            logic [4:0] c;
            a = 1'($urandom % 2);
            aw = 4'($urandom % 16);
            r = 1'($urandom % 2);
            rs = 1'($urandom % 2);
            c = 5'($urandom % 18);
            if (!rs) tag = "R3 random";
            else if (c >= 16) tag = "R6 random";
            else if (c[1:0] != 0) tag = "R5 random";
            else tag = "R4 random";
            step(a, aw, r, rs, c, tag);
        end
        step(0, 0, 0, 0, 0, "R7");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule